// File: doc/BRIEF.md
# Receiver Reference Voltage Centering Engine

This block calibrates the receive reference voltage of one 8-bit data byte lane. It walks a signed reference code upward through a fixed range. At every step it asks an external sampler for two readings of the lane's sense amplifiers. The first reading uses a sampler offset that biases toward a low output. The second uses an offset that biases toward a high output. For each step the block scores the pair of 8-bit feedback words. It remembers the first and the last reference at which the best score was seen. It also keeps an AND mask of the low-biased words and an OR mask of the high-biased words, so that it can tell whether every bit actually changed during the sweep.

When the sweep ends, the block takes the midpoint of the best-score plateau and converts it to a reference code at twice the step size, rounding away from zero. It then raises a one-cycle done pulse. The final code and a pass flag are valid together with that pulse. A controller issues `start` when the block is idle, serves each sample request, and reads the result on `done`.

Top module: `vref_center_engine`

## Requirements
- R1: After reset the block is idle: `smpReq` and `done` are 0, and `result` and `pass` are 0.
- R2: A sweep presents the reference codes -15 through +15 on `vrefCode`, in ascending order, one step at a time. Each code gets exactly one pair of sample requests.
- R3: Within a step, the first request carries `offsetCode` 15 (offset +7) and the second carries `offsetCode` 1 (offset -7). `smpReq`, `vrefCode` and `offsetCode` hold until `smpAck` is 1. Feedback is taken in the cycle `smpAck` is 1. After the second acknowledge, `smpReq` drops for at least one cycle.
- R4: The step score is popcount(offset -7 feedback) minus popcount(offset +7 feedback). The best score starts at -9. A strictly greater score sets the best score and records the step as both the low edge and the high edge. An equal score moves only the high edge to the step.
- R5: The low mask starts at 0xFF and is ANDed with every offset +7 word. The high mask starts at 0x00 and is ORed with every offset -7 word. `pass` is 1 exactly when high XOR low equals 0xFF.
- R6: `result` = adj/2, where c = low + (high-low)/2 and adj = c-1 if c < 0, otherwise c+1. All divisions truncate toward zero.
- R7: `done` is a one-cycle pulse, and `result` and `pass` are updated in that same cycle. Both hold their values until the next `done`.
- R8: `start` while idle clears the score, edges, masks and step counter. No value from an earlier sweep influences the new result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sweep (accepted when idle) |
| smpReq | output | 1 | Sample request to the sampler |
| smpAck | input | 1 | Sampler acknowledge; feedback valid |
| smpFb | input | 8 | Sense-amplifier feedback word |
| vrefCode | output | 6 | Signed reference code under test |
| offsetCode | output | 4 | Sampler offset code (15 or 1) |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | All bits toggled during the sweep |
| result | output | 6 | Signed centred reference code, double step |

## Verification
The case that needs the most care is a strict improvement and a plateau extension falling on the same compare. A score that beats the best sets both edges at once. An equal score at the last code +15 moves the high edge in the same cycle that the sweep terminates. A constant-feedback lane provokes both: the plateau spans the whole range and ends exactly at +15. The check judges the result against the expected 0 and a failed pass flag. Lanes with shifted thresholds push the midpoint negative, which exercises the rounding away from zero. A lane with one stuck bit followed by a clean lane shows that start clears the masks.

// File: rtl/vref_cal_pkg.sv
package vref_cal_pkg;

  // Strobes from the sequencer into the datapath
  typedef struct packed {
    logic clearAll;  // start of sweep: reinitialise all trackers
    logic capPos;    // capture the offset +7 feedback
    logic capNeg;    // capture the offset -7 feedback
    logic evalStep;  // compare this step's score against the best
    logic advance;   // step to the next reference code
    logic finish;    // compute centre and pass flag
  } calStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POS,
    ST_NEG,
    ST_EVAL,
    ST_FIN
  } calState_t;

endpackage

// File: rtl/vref_cal_ctrl.sv
module vref_cal_ctrl
  import vref_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       smpAck,
  input  logic       lastStep,
  output calStrobe_t strb,
  output logic       smpReq,
  output logic       negSel
);

  calState_t state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE: if (start)  stateNxt = ST_POS;
      ST_POS:  if (smpAck) stateNxt = ST_NEG;
      ST_NEG:  if (smpAck) stateNxt = ST_EVAL;
      ST_EVAL: stateNxt = lastStep ? ST_FIN : ST_POS;
      ST_FIN:  stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_comb begin
    strb          = '0;
    strb.clearAll = (state == ST_IDLE) && start;
    strb.capPos   = (state == ST_POS) && smpAck;
    strb.capNeg   = (state == ST_NEG) && smpAck;
    strb.evalStep = (state == ST_EVAL);
    strb.advance  = (state == ST_EVAL) && !lastStep;
    strb.finish   = (state == ST_FIN);
  end

  assign smpReq = (state == ST_POS) || (state == ST_NEG);
  assign negSel = (state == ST_NEG);

endmodule

// File: rtl/vref_cal_dp.sv
module vref_cal_dp
  import vref_cal_pkg::*;
#(
  parameter int LANE_W   = 8,
  parameter int CODE_W   = 6,
  parameter int OFF_W    = 4,
  parameter int SWEEP_LO = -15,
  parameter int SWEEP_HI = 15,
  parameter int OFF_POS  = 15,
  parameter int OFF_NEG  = 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  calStrobe_t               strb,
  input  logic                     negSel,
  input  logic [LANE_W-1:0]        smpFb,
  output logic                     lastStep,
  output logic signed [CODE_W-1:0] vrefCode,
  output logic [OFF_W-1:0]         offsetCode,
  output logic                     done,
  output logic                     pass,
  output logic signed [CODE_W-1:0] result
);

  localparam int SCORE_W = $clog2(LANE_W + 1) + 2;
  localparam int WIDE_W  = CODE_W + 2;
  localparam logic signed [SCORE_W-1:0] BEST_INIT = SCORE_W'(-(LANE_W + 1));
  localparam logic signed [CODE_W-1:0]  CODE_LO   = CODE_W'(SWEEP_LO);
  localparam logic signed [CODE_W-1:0]  CODE_HI   = CODE_W'(SWEEP_HI);

  function automatic logic [SCORE_W-1:0] popCount(input logic [LANE_W-1:0] w);
    logic [SCORE_W-1:0] sum;
    sum = '0;
    for (int i = 0; i < LANE_W; i++) sum = sum + SCORE_W'(w[i]);
    return sum;
  endfunction

  logic signed [CODE_W-1:0]  vrefCur, lowEdge, highEdge;
  logic signed [SCORE_W-1:0] bestScore, posCnt, negCnt, stepScore;
  logic [LANE_W-1:0]         lowMask, highMask;
  logic signed [WIDE_W-1:0]  loW, hiW, spanW, ctrW, adjW, halfW;

  assign stepScore = negCnt - posCnt;
  assign lastStep  = (vrefCur == CODE_HI);

  // Centre of the best plateau, converted to double step size
  always_comb begin
    loW   = WIDE_W'(lowEdge);
    hiW   = WIDE_W'(highEdge);
    spanW = hiW - loW;
    ctrW  = loW + spanW / $signed(WIDE_W'(2));
    adjW  = (ctrW < 0) ? ctrW - $signed(WIDE_W'(1)) : ctrW + $signed(WIDE_W'(1));
    halfW = adjW / $signed(WIDE_W'(2));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vrefCur   <= '0;
      lowEdge   <= '0;
      highEdge  <= '0;
      bestScore <= BEST_INIT;
      posCnt    <= '0;
      negCnt    <= '0;
      lowMask   <= '1;
      highMask  <= '0;
      done      <= 1'b0;
      pass      <= 1'b0;
      result    <= '0;
    end else begin
      done <= strb.finish;
      if (strb.clearAll) begin
        vrefCur   <= CODE_LO;
        lowEdge   <= '0;
        highEdge  <= '0;
        bestScore <= BEST_INIT;
        posCnt    <= '0;
        negCnt    <= '0;
        lowMask   <= '1;
        highMask  <= '0;
      end
      if (strb.capPos) begin
        lowMask <= lowMask & smpFb;
        posCnt  <= popCount(smpFb);
      end
      if (strb.capNeg) begin
        highMask <= highMask | smpFb;
        negCnt   <= popCount(smpFb);
      end
      if (strb.evalStep) begin
        if (stepScore > bestScore) begin
          bestScore <= stepScore;
          lowEdge   <= vrefCur;
          highEdge  <= vrefCur;
        end else if (stepScore == bestScore) begin
          highEdge <= vrefCur;
        end
      end
      if (strb.advance) vrefCur <= vrefCur + CODE_W'(1);
      if (strb.finish) begin
        result <= CODE_W'(halfW);
        pass   <= ((highMask ^ lowMask) == {LANE_W{1'b1}});
      end
    end
  end

  assign vrefCode   = vrefCur;
  assign offsetCode = negSel ? OFF_W'(OFF_NEG) : OFF_W'(OFF_POS);

endmodule

// File: rtl/vref_center_engine.sv
module vref_center_engine
  import vref_cal_pkg::*;
#(
  parameter int LANE_W   = 8,
  parameter int CODE_W   = 6,
  parameter int OFF_W    = 4,
  parameter int SWEEP_LO = -15,
  parameter int SWEEP_HI = 15,
  parameter int OFF_POS  = 15,
  parameter int OFF_NEG  = 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  output logic                     smpReq,
  input  logic                     smpAck,
  input  logic [LANE_W-1:0]        smpFb,
  output logic signed [CODE_W-1:0] vrefCode,
  output logic [OFF_W-1:0]         offsetCode,
  output logic                     done,
  output logic                     pass,
  output logic signed [CODE_W-1:0] result
);

  calStrobe_t strb;
  logic       negSel;
  logic       lastStep;

  vref_cal_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .smpAck   (smpAck),
    .lastStep (lastStep),
    .strb     (strb),
    .smpReq   (smpReq),
    .negSel   (negSel)
  );

  vref_cal_dp #(
    .LANE_W   (LANE_W),
    .CODE_W   (CODE_W),
    .OFF_W    (OFF_W),
    .SWEEP_LO (SWEEP_LO),
    .SWEEP_HI (SWEEP_HI),
    .OFF_POS  (OFF_POS),
    .OFF_NEG  (OFF_NEG)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .negSel     (negSel),
    .smpFb      (smpFb),
    .lastStep   (lastStep),
    .vrefCode   (vrefCode),
    .offsetCode (offsetCode),
    .done       (done),
    .pass       (pass),
    .result     (result)
  );

endmodule

// File: rtl/vref_center_checker.sv
module vref_center_checker #(
  parameter int CODE_W   = 6,
  parameter int OFF_W    = 4,
  parameter int SWEEP_LO = -15,
  parameter int SWEEP_HI = 15,
  parameter int OFF_POS  = 15,
  parameter int OFF_NEG  = 1
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     smpReq,
  input logic                     smpAck,
  input logic signed [CODE_W-1:0] vrefCode,
  input logic [OFF_W-1:0]         offsetCode,
  input logic                     done,
  input logic                     pass,
  input logic signed [CODE_W-1:0] result
);

  localparam logic signed [CODE_W-1:0] CODE_LO = CODE_W'(SWEEP_LO);
  localparam logic signed [CODE_W-1:0] CODE_HI = CODE_W'(SWEEP_HI);
  localparam logic [OFF_W-1:0] OPOS = OFF_W'(OFF_POS);
  localparam logic [OFF_W-1:0] ONEG = OFF_W'(OFF_NEG);

  p_code_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    smpReq |-> (vrefCode >= CODE_LO) && (vrefCode <= CODE_HI));

  p_code_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (smpReq && smpAck && offsetCode == ONEG && vrefCode != CODE_HI) |=> ##1
      (smpReq && offsetCode == OPOS && vrefCode == $past(vrefCode, 2) + CODE_W'(1)));

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (smpReq && !smpAck) |=> (smpReq && $stable(vrefCode) && $stable(offsetCode)));

  p_pos_then_neg_r3: assert property (@(posedge clk) disable iff (!rstN)
    (smpReq && smpAck && offsetCode == OPOS) |=> (smpReq && offsetCode == ONEG));

  p_req_drop_r3: assert property (@(posedge clk) disable iff (!rstN)
    (smpReq && smpAck && offsetCode == ONEG) |=> !smpReq);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(result) && $stable(pass)));

endmodule

bind vref_center_engine vref_center_checker #(
  .CODE_W   (CODE_W),
  .OFF_W    (OFF_W),
  .SWEEP_LO (SWEEP_LO),
  .SWEEP_HI (SWEEP_HI),
  .OFF_POS  (OFF_POS),
  .OFF_NEG  (OFF_NEG)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .smpReq     (smpReq),
  .smpAck     (smpAck),
  .vrefCode   (vrefCode),
  .offsetCode (offsetCode),
  .done       (done),
  .pass       (pass),
  .result     (result)
);

// File: tb/sim_vref_center_engine.sv
module sim_vref_center_engine;

  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic              smpReq;
  logic              smpAck = 1'b0;
  logic [7:0]        smpFb = '0;
  logic signed [5:0] vrefCode;
  logic [3:0]        offsetCode;
  logic              done;
  logic              pass;
  logic signed [5:0] result;

  int checks = 0;
  int errors = 0;

  typedef struct { int res; bit ok; int pat; } expItem_t;
  expItem_t expQ[$];

  int expVref = -15;
  bit expNeg  = 1'b0;
  int seenDone = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vref_center_engine u0 (
    .clk(clk), .rstN(rstN), .start(start), .smpReq(smpReq), .smpAck(smpAck),
    .smpFb(smpFb), .vrefCode(vrefCode), .offsetCode(offsetCode), .done(done),
    .pass(pass), .result(result)
  );

  int curPat = 0;

  // Feedback model: bit i reads 1 when (vref + offset) is below its threshold
  function automatic logic [7:0] fbFor(int pat, int v, bit neg);
    logic [7:0] w;
    int off;
    int th;
    off = neg ? -7 : 7;
    for (int i = 0; i < 8; i++) begin
      case (pat)
        0: th = i - 3;
        1: th = i - 3;
        3: th = i - 12;
        4: th = 2 * i - 4;
        default: th = -100;
      endcase
      w[i] = (v + off < th);
      if (pat == 1 && i == 3) w[i] = 1'b1;
    end
    return w;
  endfunction

  function automatic int popc(logic [7:0] w);
    int n = 0;
    for (int i = 0; i < 8; i++) n += w[i];
    return n;
  endfunction

  task automatic check(bit cond, string req, int act, int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: compute the expected outcome from the requirements, queue it, start
  task automatic runSweep(int pat);
    int best = -9, lo = 0, hi = 0, sc, c, adj;
    logic [7:0] lowM = 8'hFF, highM = 8'h00, fp, fn;
    expItem_t it;
    for (int v = -15; v <= 15; v++) begin
      fp = fbFor(pat, v, 1'b0);
      fn = fbFor(pat, v, 1'b1);
      lowM  &= fp;
      highM |= fn;
      sc = popc(fn) - popc(fp);              // R4 score
      if (sc > best) begin best = sc; lo = v; hi = v; end
      else if (sc == best) hi = v;
    end
    c   = lo + (hi - lo) / 2;                // R6 centre
    adj = (c < 0) ? c - 1 : c + 1;
    it.res = adj / 2;
    it.ok  = ((highM ^ lowM) == 8'hFF);      // R5
    it.pat = pat;
    expQ.push_back(it);
    curPat  = pat;
    expVref = -15;
    expNeg  = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done) @(negedge clk);
  endtask

  // Sampler responder with varying latency; also checks request order
  initial begin
    forever begin
      @(negedge clk);
      if (smpAck) begin
        smpAck = 1'b0;
      end else if (smpReq) begin
        check(int'(vrefCode) == expVref, "R2 vref order", int'(vrefCode), expVref);
        check(int'(offsetCode) == (expNeg ? 1 : 15), "R3 offset order",
              int'(offsetCode), expNeg ? 1 : 15);
        repeat ((int'(vrefCode) + 16) % 3) @(negedge clk);
        smpFb  = fbFor(curPat, int'(vrefCode), offsetCode == 4'd1);
        smpAck = 1'b1;
        if (expNeg) expVref++;
        expNeg = !expNeg;
      end
    end
  end

  // Monitor: pop expected items on each done pulse
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && done) begin
        seenDone++;
        if (expQ.size() == 0) begin
          check(1'b0, "R7 unexpected done", 1, 0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check(int'(result) == e.res, "R6 result", int'(result), e.res);
          check(pass == e.ok, "R5 pass", int'(pass), int'(e.ok));
          @(negedge clk);
          check(!done, "R7 done pulse width", int'(done), 0);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic signed [5:0] held;
    logic heldPass;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(smpReq == 1'b0, "R1 req idle", int'(smpReq), 0);
    check(done == 1'b0, "R1 done idle", int'(done), 0);
    check(result == 0, "R1 result zero", int'(result), 0);
    check(pass == 1'b0, "R1 pass zero", int'(pass), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(smpReq == 1'b0, "R1 no request without start", int'(smpReq), 0);

    runSweep(0);   // clean lane, R4/R5/R6
    runSweep(1);   // stuck bit 3, pass must drop (R5)
    runSweep(0);   // R8: masks from the stuck sweep must not survive
    runSweep(2);   // R4: flat plateau, equal score at +15 with termination
    runSweep(3);   // R6: negative centre, rounding away from zero
    runSweep(4);   // wider spread thresholds

    // R7 hold after done
    held = result; heldPass = pass;
    repeat (10) @(negedge clk);
    check(result == held, "R7 result hold", int'(result), int'(held));
    check(pass == heldPass, "R7 pass hold", int'(pass), int'(heldPass));
    check(seenDone == 6, "R7 done count", seenDone, 6);
    check(expQ.size() == 0, "R7 all results seen", expQ.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule